// File: doc/BRIEF.md
# Flag-Setting Integer ALU With Saturation

This block is the integer execution stage of a small RISC core. The decoder supplies one operation code, two register operands and a 16-bit immediate field. The block returns a data-width result and a write-enable for the register file. It also keeps the processor status flags in a 5-bit register. The result and the write-enable are combinational. The status register takes its new value on the clock edge that ends the operation.

Operand naming: `opnd_a` is the first (source) register and `opnd_b` is the second (destination) register. Short-immediate forms replace `opnd_a` with the sign-extended low 5 bits of `imm`. Long-immediate forms replace `opnd_a` with `imm` after sign or zero extension, chosen by the operation. Every operation class updates its own set of flags.

The saturating forms clamp the result to the signed extremes. When they clamp, they set a sticky saturation flag. Only a direct write of the status register clears that flag.

The block has no control states; its only storage is the status register. On reset the register is cleared. From then on it follows one of three transitions each cycle:
- load from `psw_wr_data`;
- update from the operation;
- hold.

Top module: `flag_alu`

## Requirements
- R1: Reset clears the status register. The status bit layout is bit 0 = Z (zero), bit 1 = S (sign), bit 2 = OV (signed overflow), bit 3 = CY (carry/borrow), bit 4 = SAT (sticky saturation).
- R2: Add computes b+a, subtract computes b−a and reverse subtract computes a−b. Compare computes b−a and keeps `wr_en` low. All four set Z and S from the result, set OV on signed overflow, and set CY to the carry-out for addition or the unsigned borrow for subtraction.
- R3: The short-immediate add, compare and saturating add use `imm[4:0]`, sign-extended, in place of `opnd_a`.
- R4: Saturating add, subtract (b−a), subtract-immediate and reverse subtract write 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow. Z and S follow the written value, and CY and OV follow the unclamped arithmetic.
- R5: SAT becomes 1 when a saturating operation overflows. No other ALU operation clears it.
- R6: Add-immediate and saturating subtract-immediate sign-extend `imm`. OR-immediate, XOR-immediate and AND-immediate zero-extend it.
- R7: OR, XOR, AND and NOT (NOT gives ~a) set Z and S from the result, clear OV and leave CY unchanged.
- R8: AND-immediate sets Z from the result, clears S and OV, and leaves CY unchanged.
- R9: Shifts act on `opnd_b`. The count is the low 5 bits of `opnd_a`, so higher bits are ignored. The arithmetic right shift copies the sign bit in. Every shift sets Z and S from the result and clears OV. CY is the last bit shifted out, or 0 when the count is 0.
- R10: The high-immediate add gives b + (imm<<16), and the offset add gives b + sign-extended imm. Neither changes any flag.
- R11: `psw_wr_en` loads `psw_wr_data` into the status register. This takes priority over an operation in the same cycle.
- R12: With `op_valid` low, `wr_en` is low and the status register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 5 | Operation code (`alu_op_e`) |
| opnd_a | input | 32 | First register operand / shift count |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| psw_wr_en | input | 1 | Direct status register write |
| psw_wr_data | input | 5 | Value for the direct write |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register-file write enable |
| psw | output | 5 | Status register |

## Verification
The assertions assume that `op_sel` holds one of the defined codes whenever `op_valid` is high, and that the data inputs carry no unknown bits. Several flag properties also assume that no direct status write arrives in the same cycle, and they exclude that case in their antecedents.

The bench meets the first assumption by stepping through only the enumerated operation values. It drives every input to a known value at every cycle. It issues direct writes only in the directed tests, which are limited to the status write (R11), SAT stickiness (R5) and idle hold (R12).

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [4:0] {
        AOP_ADD      = 5'd0,
        AOP_ADD_I5   = 5'd1,
        AOP_ADDI     = 5'd2,
        AOP_SUB      = 5'd3,
        AOP_SUBR     = 5'd4,
        AOP_CMP      = 5'd5,
        AOP_CMP_I5   = 5'd6,
        AOP_SATADD   = 5'd7,
        AOP_SATADD_I5= 5'd8,
        AOP_SATSUB   = 5'd9,
        AOP_SATSUBI  = 5'd10,
        AOP_SATSUBR  = 5'd11,
        AOP_OR       = 5'd12,
        AOP_ORI      = 5'd13,
        AOP_XOR      = 5'd14,
        AOP_XORI     = 5'd15,
        AOP_AND      = 5'd16,
        AOP_ANDI     = 5'd17,
        AOP_NOT      = 5'd18,
        AOP_SHL      = 5'd19,
        AOP_SHR      = 5'd20,
        AOP_SAR      = 5'd21,
        AOP_MOVHI    = 5'd22,
        AOP_MOVEA    = 5'd23
    } alu_op_e;

    localparam int AOP_COUNT = 24;

    localparam int FLG_Z   = 0;
    localparam int FLG_S   = 1;
    localparam int FLG_OV  = 2;
    localparam int FLG_CY  = 3;
    localparam int FLG_SAT = 4;
    localparam int FLG_W   = 5;

    typedef enum logic [2:0] {
        SRC_REG, SRC_SIMM5, SRC_SIMM16, SRC_UIMM16, SRC_HI16
    } src_e;

    typedef enum logic [2:0] {
        CLS_ARITH, CLS_SAT, CLS_LOGIC, CLS_ANDZ, CLS_SHIFT, CLS_NOFLAG
    } cls_e;

    typedef enum logic [1:0] { LG_OR, LG_XOR, LG_AND, LG_NOT } lg_e;
    typedef enum logic [1:0] { SH_LL, SH_RL, SH_RA } sh_e;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] clamped,
    output logic              carry,
    output logic              ovf
);
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] rhs_eff;
    logic              c_out;

    always_comb begin
        rhs_eff        = sub ? ~rhs : rhs;
        {c_out, sum}   = {1'b0, lhs} + {1'b0, rhs_eff} + {{DATA_W{1'b0}}, sub};
        carry          = sub ? ~c_out : c_out;
        ovf            = (lhs[DATA_W-1] == rhs_eff[DATA_W-1]) &&
                         (sum[DATA_W-1] != lhs[DATA_W-1]);
        if (ovf)
            clamped = lhs[DATA_W-1] ? NEG_MIN : POS_MAX;
        else
            clamped = sum;
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  lg_e               mode,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (mode)
            LG_OR:   res = y | x;
            LG_XOR:  res = y ^ x;
            LG_AND:  res = y & x;
            LG_NOT:  res = ~x;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   cnt,
    input  sh_e               mode,
    output logic [DATA_W-1:0] res,
    output logic              cy_out
);
    logic [DATA_W:0] ext;

    always_comb begin
        unique case (mode)
            SH_LL: begin
                ext    = {1'b0, val} << cnt;
                res    = ext[DATA_W-1:0];
                cy_out = ext[DATA_W];
            end
            SH_RL: begin
                ext    = {val, 1'b0} >> cnt;
                res    = ext[DATA_W:1];
                cy_out = ext[0];
            end
            SH_RA: begin
                ext    = $unsigned($signed({val, 1'b0}) >>> cnt);
                res    = ext[DATA_W:1];
                cy_out = ext[0];
            end
            default: begin
                ext    = '0;
                res    = '0;
                cy_out = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM5_W  = 5,
    parameter int IMM16_W = 16,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [4:0]         op_sel,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [IMM16_W-1:0] imm,
    input  logic               psw_wr_en,
    input  logic [FLG_W-1:0]   psw_wr_data,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic [FLG_W-1:0]   psw
);
    src_e  src_sel;
    cls_e  cls;
    lg_e   lmode;
    sh_e   smode;
    logic  do_sub, swap, writes;

    logic [DATA_W-1:0] src1, lhs, rhs;
    logic [DATA_W-1:0] as_sum, as_clamp, lg_res, sh_res;
    logic              as_cy, as_ov, sh_cy;
    logic [FLG_W-1:0]  psw_q, psw_nxt;

    // decode: operand source, flag class and unit mode
    always_comb begin
        src_sel = SRC_REG;
        cls     = CLS_ARITH;
        lmode   = LG_OR;
        smode   = SH_LL;
        do_sub  = 1'b0;
        swap    = 1'b0;
        writes  = 1'b1;
        unique case (alu_op_e'(op_sel))
            AOP_ADD:       ;
            AOP_ADD_I5:    src_sel = SRC_SIMM5;
            AOP_ADDI:      src_sel = SRC_SIMM16;
            AOP_SUB:       do_sub = 1'b1;
            AOP_SUBR:      begin do_sub = 1'b1; swap = 1'b1; end
            AOP_CMP:       begin do_sub = 1'b1; writes = 1'b0; end
            AOP_CMP_I5:    begin do_sub = 1'b1; writes = 1'b0; src_sel = SRC_SIMM5; end
            AOP_SATADD:    cls = CLS_SAT;
            AOP_SATADD_I5: begin cls = CLS_SAT; src_sel = SRC_SIMM5; end
            AOP_SATSUB:    begin cls = CLS_SAT; do_sub = 1'b1; end
            AOP_SATSUBI:   begin cls = CLS_SAT; do_sub = 1'b1; src_sel = SRC_SIMM16; end
            AOP_SATSUBR:   begin cls = CLS_SAT; do_sub = 1'b1; swap = 1'b1; end
            AOP_OR:        cls = CLS_LOGIC;
            AOP_ORI:       begin cls = CLS_LOGIC; src_sel = SRC_UIMM16; end
            AOP_XOR:       begin cls = CLS_LOGIC; lmode = LG_XOR; end
            AOP_XORI:      begin cls = CLS_LOGIC; lmode = LG_XOR; src_sel = SRC_UIMM16; end
            AOP_AND:       begin cls = CLS_LOGIC; lmode = LG_AND; end
            AOP_ANDI:      begin cls = CLS_ANDZ;  lmode = LG_AND; src_sel = SRC_UIMM16; end
            AOP_NOT:       begin cls = CLS_LOGIC; lmode = LG_NOT; end
            AOP_SHL:       begin cls = CLS_SHIFT; smode = SH_LL; end
            AOP_SHR:       begin cls = CLS_SHIFT; smode = SH_RL; end
            AOP_SAR:       begin cls = CLS_SHIFT; smode = SH_RA; end
            AOP_MOVHI:     begin cls = CLS_NOFLAG; src_sel = SRC_HI16; end
            AOP_MOVEA:     begin cls = CLS_NOFLAG; src_sel = SRC_SIMM16; end
            default:       begin cls = CLS_NOFLAG; writes = 1'b0; end
        endcase
    end

    // first-operand selection
    always_comb begin
        unique case (src_sel)
            SRC_REG:    src1 = opnd_a;
            SRC_SIMM5:  src1 = {{(DATA_W-IMM5_W){imm[IMM5_W-1]}}, imm[IMM5_W-1:0]};
            SRC_SIMM16: src1 = {{(DATA_W-IMM16_W){imm[IMM16_W-1]}}, imm};
            SRC_UIMM16: src1 = {{(DATA_W-IMM16_W){1'b0}}, imm};
            SRC_HI16:   src1 = DATA_W'(imm) << IMM16_W;
            default:    src1 = '0;
        endcase
        lhs = swap ? src1   : opnd_b;
        rhs = swap ? opnd_b : src1;
    end

    flag_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .lhs(lhs), .rhs(rhs), .sub(do_sub),
        .sum(as_sum), .clamped(as_clamp), .carry(as_cy), .ovf(as_ov)
    );

    flag_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .x(src1), .y(opnd_b), .mode(lmode), .res(lg_res)
    );

    flag_alu_shift #(.DATA_W(DATA_W)) u_shift (
        .val(opnd_b), .cnt(opnd_a[SH_W-1:0]), .mode(smode),
        .res(sh_res), .cy_out(sh_cy)
    );

    // result and flag outputs
    always_comb begin
        psw_nxt = psw_q;
        unique case (cls)
            CLS_SAT:              result = as_clamp;
            CLS_LOGIC, CLS_ANDZ:  result = lg_res;
            CLS_SHIFT:            result = sh_res;
            default:              result = as_sum;
        endcase
        unique case (cls)
            CLS_ARITH, CLS_SAT: begin
                psw_nxt[FLG_Z]  = (result == '0);
                psw_nxt[FLG_S]  = result[DATA_W-1];
                psw_nxt[FLG_CY] = as_cy;
                psw_nxt[FLG_OV] = as_ov;
                if (cls == CLS_SAT && as_ov)
                    psw_nxt[FLG_SAT] = 1'b1;
            end
            CLS_LOGIC, CLS_SHIFT: begin
                psw_nxt[FLG_Z]  = (result == '0);
                psw_nxt[FLG_S]  = result[DATA_W-1];
                psw_nxt[FLG_OV] = 1'b0;
                if (cls == CLS_SHIFT)
                    psw_nxt[FLG_CY] = sh_cy;
            end
            CLS_ANDZ: begin
                psw_nxt[FLG_Z]  = (result == '0);
                psw_nxt[FLG_S]  = 1'b0;
                psw_nxt[FLG_OV] = 1'b0;
            end
            default: ;
        endcase
        wr_en = op_valid & writes;
    end

    // status register: reset, direct load, operation update or hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            psw_q <= '0;
        else if (psw_wr_en)
            psw_q <= psw_wr_data;
        else if (op_valid)
            psw_q <= psw_nxt;
    end

    assign psw = psw_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [4:0]       op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic             psw_wr_en,
    input logic [FLG_W-1:0] psw_wr_data,
    input logic             wr_en,
    input logic [FLG_W-1:0] psw
);
    logic flag_op;
    assign flag_op = op_valid && !psw_wr_en;

    a_r11_status_load: assert property (@(posedge clk) disable iff (!rst_n)
        psw_wr_en |=> psw == $past(psw_wr_data));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !psw_wr_en) |=> $stable(psw));

    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !wr_en);

    a_r2_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == AOP_CMP || op_sel == AOP_CMP_I5)) |-> !wr_en);

    a_r5_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (psw[FLG_SAT] && !psw_wr_en) |=> psw[FLG_SAT]);

    a_r10_mov_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op && (op_sel == AOP_MOVHI || op_sel == AOP_MOVEA)) |=> $stable(psw));

    a_r8_andi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op && op_sel == AOP_ANDI) |=> (!psw[FLG_S] && !psw[FLG_OV]));

    a_r7_logic_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op && (op_sel == AOP_OR || op_sel == AOP_XOR || op_sel == AOP_AND
                     || op_sel == AOP_NOT)) |=> (!psw[FLG_OV] && $stable(psw[FLG_CY])));

    a_r9_zero_count_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op && (op_sel == AOP_SHL || op_sel == AOP_SHR || op_sel == AOP_SAR)
         && opnd_a[4:0] == 5'd0) |=> (!psw[FLG_CY] && !psw[FLG_OV]));
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
    .wr_en(wr_en), .psw(psw)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/100ps
module flag_alu_tb;
    import flag_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm = '0;
    logic        psw_wr_en = 1'b0;
    logic [4:0]  psw_wr_data = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [4:0]  psw;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [4:0] exp_psw = '0;

    always #2.5 clk = ~clk;

    flag_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .result(result), .wr_en(wr_en), .psw(psw)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic string tag_of(input alu_op_e op);
        case (op)
            AOP_ADD_I5, AOP_CMP_I5, AOP_SATADD_I5:      return "R3";
            AOP_ADDI, AOP_SATSUBI, AOP_ORI, AOP_XORI:   return "R6";
            AOP_SATADD, AOP_SATSUB, AOP_SATSUBR:        return "R4";
            AOP_OR, AOP_XOR, AOP_AND, AOP_NOT:          return "R7";
            AOP_ANDI:                                   return "R8";
            AOP_SHL, AOP_SHR, AOP_SAR:                  return "R9";
            AOP_MOVHI, AOP_MOVEA:                       return "R10";
            default:                                    return "R2";
        endcase
    endfunction

    // arithmetic reference in 64-bit signed integers
    function automatic void arith(input bit sub, input logic [31:0] l, r,
                                  output logic [31:0] res, output logic cy,
                                  output logic ov, output longint sv);
        longint sl = longint'($signed(l));
        longint sr = longint'($signed(r));
        sv  = sub ? sl - sr : sl + sr;
        cy  = sub ? (l < r) : ((64'(l) + 64'(r)) > 64'hFFFF_FFFF);
        ov  = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        res = sv[31:0];
    endfunction

    function automatic void model(input alu_op_e op, input logic [31:0] a, b,
                                  input logic [15:0] im, input logic [4:0] pin,
                                  output logic [31:0] r, output logic w,
                                  output logic [4:0] p);
        logic [31:0] s5  = {{27{im[4]}}, im[4:0]};
        logic [31:0] s16 = {{16{im[15]}}, im};
        logic [31:0] z16 = {16'h0, im};
        logic cy = 1'b0, ov = 1'b0;
        longint sv = 0;
        int kind = 0;
        int n = int'(a[4:0]);
        logic [63:0] t;
        p = pin; w = 1'b1; r = '0;
        case (op)
            AOP_ADD:       arith(0, b, a, r, cy, ov, sv);
            AOP_ADD_I5:    arith(0, b, s5, r, cy, ov, sv);
            AOP_ADDI:      arith(0, b, s16, r, cy, ov, sv);
            AOP_SUB:       arith(1, b, a, r, cy, ov, sv);
            AOP_SUBR:      arith(1, a, b, r, cy, ov, sv);
            AOP_CMP:       begin arith(1, b, a, r, cy, ov, sv); w = 0; end
            AOP_CMP_I5:    begin arith(1, b, s5, r, cy, ov, sv); w = 0; end
            AOP_SATADD:    begin arith(0, b, a, r, cy, ov, sv); kind = 1; end
            AOP_SATADD_I5: begin arith(0, b, s5, r, cy, ov, sv); kind = 1; end
            AOP_SATSUB:    begin arith(1, b, a, r, cy, ov, sv); kind = 1; end
            AOP_SATSUBI:   begin arith(1, b, s16, r, cy, ov, sv); kind = 1; end
            AOP_SATSUBR:   begin arith(1, a, b, r, cy, ov, sv); kind = 1; end
            AOP_OR:        begin r = b | a;   kind = 2; end
            AOP_ORI:       begin r = b | z16; kind = 2; end
            AOP_XOR:       begin r = b ^ a;   kind = 2; end
            AOP_XORI:      begin r = b ^ z16; kind = 2; end
            AOP_AND:       begin r = b & a;   kind = 2; end
            AOP_NOT:       begin r = ~a;      kind = 2; end
            AOP_ANDI:      begin r = b & z16; kind = 3; end
            AOP_SHL: begin
                t = {32'h0, b} << n; r = t[31:0]; cy = (n != 0) && t[32]; kind = 4;
            end
            AOP_SHR: begin
                t = {b, 32'h0} >> n; r = t[63:32]; cy = (n != 0) && t[31]; kind = 4;
            end
            AOP_SAR: begin
                t = $unsigned($signed({b, 32'h0}) >>> n); r = t[63:32];
                cy = (n != 0) && t[31]; kind = 4;
            end
            AOP_MOVHI:     begin r = b + (z16 << 16); kind = 5; end
            AOP_MOVEA:     begin r = b + s16; kind = 5; end
            default:       kind = 5;
        endcase
        if (kind == 1) begin
            if (sv > 64'sd2147483647) r = 32'h7FFF_FFFF;
            else if (sv < -64'sd2147483648) r = 32'h8000_0000;
            if (ov) p[4] = 1'b1;
        end
        case (kind)
            0, 1: begin p[0] = (r == 0); p[1] = r[31]; p[2] = ov; p[3] = cy; end
            2:    begin p[0] = (r == 0); p[1] = r[31]; p[2] = 0; end
            3:    begin p[0] = (r == 0); p[1] = 0;     p[2] = 0; end
            4:    begin p[0] = (r == 0); p[1] = r[31]; p[2] = 0; p[3] = cy; end
            default: ;
        endcase
    endfunction

    // called at a falling edge; leaves the bench at the next falling edge
    task automatic run_op(input alu_op_e op, input logic [31:0] a, b,
                          input logic [15:0] im);
        logic [31:0] er; logic ew; logic [4:0] ep;
        string tg = tag_of(op);
        model(op, a, b, im, exp_psw, er, ew, ep);
        op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; imm = im;
        #1;
        check(wr_en === ew, (op == AOP_CMP || op == AOP_CMP_I5) ? "R2 cmp wr_en" : {tg, " wr_en"},
              32'(wr_en), 32'(ew));
        if (ew) check(result === er, {tg, " result"}, result, er);
        @(negedge clk);
        check(psw === ep, {tg, " flags"}, 32'(psw), 32'(ep));
        exp_psw = ep;
        op_valid = 1'b0;
    endtask

    logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h0000_001F, 32'h0000_0020, 32'hA5A5_0003};
    logic [15:0] imms [5] = '{16'h0000, 16'h8001, 16'h7FFF, 16'hFFF0, 16'h000F};

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(psw === 5'h00, "R1 reset psw", 32'(psw), 32'h0);
        check(wr_en === 1'b0, "R1 reset wr_en", 32'(wr_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of every operation over corner operand pairs
        for (int k = 0; k < AOP_COUNT; k++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(alu_op_e'(k), vals[i], vals[j], imms[(i + j) % 5]);

        // R5: SAT set by a clamp, kept through other operations
        psw_wr_en = 1'b1; psw_wr_data = 5'h00; @(negedge clk); psw_wr_en = 1'b0;
        exp_psw = 5'h00;
        run_op(AOP_SATADD, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0);
        check(psw[4] === 1'b1, "R5 sat set", 32'(psw[4]), 32'h1);
        run_op(AOP_ADD, 32'h1, 32'h1, 16'h0);
        run_op(AOP_SHL, 32'h1, 32'h1, 16'h0);
        run_op(AOP_SATSUB, 32'h1, 32'h5, 16'h0);
        check(psw[4] === 1'b1, "R5 sat kept", 32'(psw[4]), 32'h1);

        // R11: direct write clears SAT, wins over a same-cycle operation
        psw_wr_en = 1'b1; psw_wr_data = 5'h0A;
        op_valid = 1'b1; op_sel = AOP_SATADD; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h7FFF_FFFF;
        @(negedge clk);
        check(psw === 5'h0A, "R11 write priority", 32'(psw), 32'h0A);
        psw_wr_data = 5'h1F; op_valid = 1'b0;
        @(negedge clk);
        check(psw === 5'h1F, "R11 write all ones", 32'(psw), 32'h1F);
        psw_wr_en = 1'b0;

        // R12: idle cycle with inputs that would change flags
        op_valid = 1'b0; op_sel = AOP_SUB; opnd_a = 32'h5; opnd_b = 32'h5;
        #1;
        check(wr_en === 1'b0, "R12 idle wr_en", 32'(wr_en), 32'h0);
        @(negedge clk);
        check(psw === 5'h1F, "R12 idle hold", 32'(psw), 32'h1F);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule